// File: doc/BRIEF.md
# Sub-word load/store memory lane

A synchronous data memory made of 64-bit rows, each holding eight bytes, that serves naturally aligned loads and stores of one, two, four or eight bytes. The byte address is split into a row index and a byte offset inside the row. Narrow accesses are moved in and out of their byte lanes by shifting and masking. A narrow store reads the row, replaces only its own lane and writes the row back, so the other bytes keep their values.

Each request can ask for a byte reversal within the access width. This applies to load results and to store data. An access whose offset is not a multiple of its width does not complete. Instead the block reports an error on the response. Every request gets a registered response one cycle later.

Top module: `lane_mem`

## Requirements
- R1: After reset every row reads as zero and `rsp_valid`, `rsp_err` and `rsp_rdata` are 0.
- R2: The byte offset is `req_addr[2:0]` and the row index is `req_addr[AW-1:3]`. Byte k of a row occupies bits 8k+7..8k, so byte 0 is least significant.
- R3: A legal load presented with `req_valid` gives `rsp_valid`=1 on the next cycle. `rsp_rdata` then holds the accessed bytes shifted down to bit 0 and zero-extended above the access width.
- R4: A legal store narrower than eight bytes changes only the bytes it covers. Every other byte of the row keeps its previous value.
- R5: A legal eight-byte store replaces the whole row with `req_wdata`.
- R6: An access whose offset is not a multiple of its width is treated as illegal. On the next cycle it gives `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0, and it leaves the memory unchanged.
- R7: A load with `req_swap`=1 returns its bytes in reverse order within the access width. The lowest-addressed byte appears in the most significant byte of that width.
- R8: A store with `req_swap`=1 reverses the bytes of `req_wdata[8n-1:0]` before writing them. Byte n-1 of the data is written to the lowest address.
- R9: A legal store gives `rsp_valid`=1, `rsp_err`=0 and `rsp_rdata`=0 on the next cycle. A load issued in the very next cycle sees the stored data.
- R10: `req_size` encodes the width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Store data above the access width is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all rows |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address (AW = log2(ROWS)+3) |
| req_size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, right-aligned |
| req_swap | input | 1 | Reverse byte order within the access width |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Load result, right-aligned; 0 for stores and errors |
| rsp_err | output | 1 | Previous request was misaligned |

## Verification
Every request is answered exactly one clock edge later, whether it is a load, a store or an error. The bench therefore pushes one expected response for each request it drives. It pops that response one nanosecond after the next rising edge and flags any response that is missing or unexpected. A store changes the row at the same edge that produces its response, so a load issued in the next cycle must already see the new bytes. The bench checks this with back-to-back store and load pairs, and it checks misaligned accesses by reading the row back afterwards.

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int ROWS = 64,
  localparam int RB = $clog2(ROWS),
  localparam int AW = RB + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [63:0]   req_wdata,
  input  logic          req_swap,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_err
);

  logic [63:0] mem [ROWS];

  function automatic logic [63:0] brev(input logic [63:0] d, input logic [1:0] sz);
    logic [63:0] r;
    int n;
    r = '0;
    n = 1 << sz;
    for (int i = 0; i < 8; i++)
      if (i < n) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    return r;
  endfunction

  logic [63:0] mask;
  always_comb begin
    case (req_size)
      2'd0:    mask = 64'h0000_0000_0000_00FF;
      2'd1:    mask = 64'h0000_0000_0000_FFFF;
      2'd2:    mask = 64'h0000_0000_FFFF_FFFF;
      default: mask = '1;
    endcase
  end

  wire [2:0]    off    = req_addr[2:0];
  wire [RB-1:0] row    = req_addr[AW-1:3];
  wire [2:0]    lowm   = 3'((4'd1 << req_size) - 4'd1);
  wire          misal  = (off & lowm) != 3'd0;
  wire [5:0]    sh     = {off, 3'b000};
  wire [63:0]   cur    = mem[row];

  wire [63:0] ld_raw = (cur >> sh) & mask;
  wire [63:0] ld_val = req_swap ? brev(ld_raw, req_size) : ld_raw;
  wire [63:0] st_raw = req_wdata & mask;
  wire [63:0] st_val = req_swap ? brev(st_raw, req_size) : st_raw;
  wire [63:0] merged = (cur & ~(mask << sh)) | (st_val << sh);
  wire [63:0] newrow = (req_size == 2'd3) ? st_val : merged;

  wire do_store = req_valid && req_write && !misal;
  wire do_load  = req_valid && !req_write && !misal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && misal;
      rsp_rdata <= do_load ? ld_val : 64'd0;
      if (do_store) mem[row] <= newrow;
    end
  end

  // R3: one response per request, one cycle later
  a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3: load result zero-extended above its width
  a_r3_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (rsp_rdata & ~$past(mask)) == 64'd0);
  // R6: error carries no data and leaves the row alone
  a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 64'd0);
  a_r6_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && misal) |=> mem[$past(row)] == $past(cur));
  // R4: a store touches only its own lane
  a_r4_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
    do_store |=> ((mem[$past(row)] ^ $past(cur)) & ~$past(mask << sh)) == 64'd0);
  // R9: store response carries no data
  a_r9_store_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == 64'd0);

endmodule

// File: tb/tb_lane_mem.sv
module tb_lane_mem;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 64;
  localparam int AW = $clog2(ROWS) + 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 0;
  logic [63:0]   req_wdata = '0;
  logic          req_swap = 0;
  logic          rsp_valid;
  logic [63:0]   rsp_rdata;
  logic          rsp_err;

  lane_mem #(.ROWS(ROWS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] model [ROWS*8];
  logic [64:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input int addr, input int sz, input bit wr,
                        input logic [63:0] wd, input bit sw);
    int n, off;
    logic [63:0] ev;
    n = 1 << sz;
    off = addr % 8;
    ev = '0;
    @(negedge clk);
    req_valid = 1; req_addr = AW'(addr); req_size = 2'(sz);
    req_write = wr; req_wdata = wd; req_swap = sw;
    if (off % n != 0) begin
      exp_q.push_back({1'b1, 64'd0});
    end else if (wr) begin
      for (int i = 0; i < n; i++)
        model[addr + i] = sw ? wd[8*(n-1-i) +: 8] : wd[8*i +: 8];
      exp_q.push_back({1'b0, 64'd0});
    end else begin
      for (int i = 0; i < n; i++)
        ev[8*i +: 8] = sw ? model[addr + n-1-i] : model[addr + i];
      exp_q.push_back({1'b0, ev});
    end
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (rsp_valid) begin
          if (exp_q.size() == 0) chk("R3 unexpected response", 65'd1, 65'd0);
          else chk(tag_q.pop_front(), {rsp_err, rsp_rdata}, exp_q.pop_front());
        end else if (exp_q.size() != 0) begin
          chk({tag_q.pop_front(), " missing response"}, 65'd0, 65'd1);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ROWS*8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {rsp_valid, rsp_err, rsp_rdata} , 66'd0);
    rst_n = 1;
    access("R1 unwritten row 0", 0, 3, 0, 0, 0);
    access("R1 unwritten row 63", 63*8, 3, 0, 0, 0);
    access("R5 full store", 8, 3, 1, 64'h8877_6655_4433_2211, 0);
    access("R5 full load", 8, 3, 0, 0, 0);
    access("R2 byte 0 lsb", 8, 0, 0, 0, 0);
    access("R2 byte 7", 15, 0, 0, 0, 0);
    access("R10 half at 2", 10, 1, 0, 0, 0);
    access("R10 word at 4", 12, 2, 0, 0, 0);
    access("R4 byte store", 11, 0, 1, 64'hFFFF_FFFF_FFFF_FFAB, 0);
    access("R4 row after byte store", 8, 3, 0, 0, 0);
    access("R4 half store", 14, 1, 1, 64'h1234_5678_9ABC_CDEF, 0);
    access("R4 word store", 16, 2, 1, 64'hDEAD_BEEF, 0);
    access("R4 row after half", 8, 3, 0, 0, 0);
    access("R9 load right after store", 16, 3, 0, 0, 0);
    access("R6 misaligned half load", 9, 1, 0, 0, 0);
    access("R6 misaligned word store", 18, 2, 1, 64'h5555_5555, 0);
    access("R6 misaligned full store", 20, 3, 1, 64'h1, 0);
    access("R6 row unchanged", 16, 3, 0, 0, 0);
    access("R7 swapped word load", 8, 2, 0, 0, 1);
    access("R7 swapped full load", 8, 3, 0, 0, 1);
    access("R8 swapped half store", 24, 1, 1, 64'hA1B2, 1);
    access("R8 swapped full store", 32, 3, 1, 64'h0102_0304_0506_0708, 1);
    access("R8 row after half swap", 24, 3, 0, 0, 0);
    access("R8 row after full swap", 32, 3, 0, 0, 0);
    access("R7 swapped byte load", 33, 0, 0, 0, 1);
    idle();
    access("R9 store after idle", 40, 0, 1, 64'h7E, 0);
    access("R9 load sees store", 40, 0, 0, 0, 0);
    for (int k = 0; k < 300; k++) begin
      int sz, a;
      sz = $urandom_range(0, 3);
      a = $urandom_range(0, ROWS*8 - 1);
      if (k % 7 != 0) a = a & ~((1 << sz) - 1);
      access("R3 random", a, sz, 1'($urandom_range(0, 1)),
             {$urandom, $urandom}, 1'($urandom_range(0, 1)));
    end
    for (int r = 0; r < ROWS; r++) access("R4 final row", r*8, 3, 0, 0, 0);
    idle();
    repeat (3) @(negedge clk);
    chk("R3 queue drained", 65'(exp_q.size()), 65'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule